// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block gives software a two-register window onto the management registers of external Ethernet PHYs. Software puts the PHY address, the register address and an operation request into a single control word. A write to the control register with a read or write request starts one complete serial management frame on the MDC clock and MDIO data pins. The requested operation bit reads back as 1 for as long as the frame runs and clears itself when the frame has finished. For a write frame, the 16-bit payload is taken from the data register, which software loads beforehand. For a read frame, the 16 bits returned by the PHY replace the contents of the data register when the operation bit clears.

MDC is derived from the system clock. Each MDC half-period lasts `MDC_HALF_DIV` system cycles, and the parameter is chosen so that MDC stays at or below 2.5 MHz. The register port is a plain write-enable and select port with no back-pressure: it accepts a write in every cycle. Control and data writes that arrive while a frame is running are dropped. Register reads are combinational on the select input. No stream interface is involved.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control register and the data register both read 0x0000, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: The control word holds the PHY address in bits 13:9 and the register address in bits 8:4, and these fields read back as written. A control write in which bits 1:0 are both 0 updates the fields but starts no frame.
- R3: Control bit 0 set starts a read frame. Bit 0 then reads 1 until the frame ends and reads 0 afterwards. If bits 0 and 1 are both set, the frame is a read.
- R4: Control bit 1 set, with bit 0 clear, starts a write frame that carries the data register contents. Bit 1 reads 1 until the frame ends, and the data register is left unchanged.
- R5: A frame is 64 MDC periods, sent MSB first in this order: 32 ones, start pattern 01, opcode (10 for read, 01 for write), 5-bit PHY address, 5-bit register address, turnaround (10 for write), then 16 data bits. MDIO changes only while MDC is low.
- R6: In a read frame, MDIO is released from the first turnaround bit (bit 46) to the end of the frame. The 16 data bits are sampled on rising MDC edges, MSB first, and appear in the data register in the same cycle that the operation bit clears.
- R7: A read from an absent PHY, where MDIO stays pulled high, returns 0xFFFF.
- R8: MDC stays low while idle. During a frame each MDC half-period is `MDC_HALF_DIV` system cycles, so a frame keeps the operation bit set for exactly 128*`MDC_HALF_DIV` cycles.
- R9: While a frame is in progress, writes to the control register and to the data register are ignored. The running frame, the address fields and the read result are all left unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 control, 1 data (for both read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; 0 releases the line |

## Verification
A control write sampled at edge E0 makes the operation bit visible right after E0. The first MDC rise follows at E0+`MDC_HALF_DIV`. The bit clears, and a read result lands in the data register, at edge E0+128*`MDC_HALF_DIV` (E0+512 with the default of 4). Each frame task therefore counts exactly 511 edges and checks that the bit is still set, then advances one more edge and checks the cleared bit and the data. All samples are taken 1 time unit after a rising edge. Frame bits and the output-enable pattern are captured by the bench on every rising MDC edge and compared after the frame. Writes made during a frame are checked a known number of edges after they are made, by reading back the fields through the normal register port.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int CTRL_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int TA_SLOT   = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int DATA_SLOT = TA_SLOT + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  // control word field positions (software-visible)
  localparam int RD_BIT    = 0;
  localparam int WR_BIT    = 1;
  localparam int REG_LSB   = 4;
  localparam int PHY_LSB   = 9;

  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
  } mgmt_addr_t;

  // whole serial frame, first bit on the wire in the MSB
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic rd, input mgmt_addr_t a, input logic [DATA_W-1:0] d);
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    opc = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    pay = rd ? {DATA_W{1'b1}} : d;
    return {{PRE_LEN{1'b1}}, 2'b01, opc, a.phy, a.regad, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  logic mdc_q;
  logic edge_due;

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign edge_due = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (!run)                          cnt_q <= '0;
        else if (cnt_q == CW'(HALF_DIV - 1))    cnt_q <= '0;
        else                                    cnt_q <= cnt_q + 1'b1;
      end
      assign edge_due = run && (cnt_q == CW'(HALF_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdc_q <= 1'b0;
    else if (!run)     mdc_q <= 1'b0;
    else if (edge_due) mdc_q <= ~mdc_q;
  end

  assign mdc      = mdc_q;
  assign rise_stb = edge_due && !mdc_q;
  assign fall_stb = edge_due &&  mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 is_rd,
  output logic [IDX_W-1:0]     bit_idx,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rx_data
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [DATA_W-1:0]    rx_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, rd_q;
  logic                 last_slot;

  assign last_slot = (idx_q == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      rx_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        rd_q   <= start_rd;
        idx_q  <= '0;
        sh_q   <= frame;
      end
    end else begin
      if (rise_stb && rd_q && (idx_q >= IDX_W'(DATA_SLOT)))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (last_slot) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign bit_idx = idx_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_SLOT)));
  assign done    = busy_q && fall_stb && last_slot;
  assign rx_data = rx_q;
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              busy,
  input  logic              op_rd,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output mgmt_addr_t        addr,
  output logic [DATA_W-1:0] data,
  output logic              start,
  output logic              start_rd,
  output logic [CTRL_W-1:0] rdata
);
  mgmt_addr_t        addr_q;
  logic [DATA_W-1:0] data_q;
  logic              ctrl_wr, data_wr;
  logic [CTRL_W-1:0] ctrl_view;

  assign ctrl_wr  = wr_en && !sel && !busy;
  assign data_wr  = wr_en &&  sel && !busy;
  assign start    = ctrl_wr && (wdata[RD_BIT] || wdata[WR_BIT]);
  assign start_rd = wdata[RD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_wr) begin
        addr_q.phy   <= wdata[PHY_LSB +: PHY_AW];
        addr_q.regad <= wdata[REG_LSB +: REG_AW];
      end
      if (data_wr)            data_q <= wdata;
      else if (done && op_rd) data_q <= rx_data;
    end
  end

  always_comb begin
    ctrl_view                       = '0;
    ctrl_view[PHY_LSB +: PHY_AW]    = addr_q.phy;
    ctrl_view[REG_LSB +: REG_AW]    = addr_q.regad;
    ctrl_view[RD_BIT]               = busy &&  op_rd;
    ctrl_view[WR_BIT]               = busy && !op_rd;
  end

  assign rdata = sel ? data_q : ctrl_view;
  assign addr  = addr_q;
  assign data  = data_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  mgmt_addr_t           addr;
  mgmt_addr_t           new_addr;
  logic [DATA_W-1:0]    data_q;
  logic [DATA_W-1:0]    rx_data;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     bit_idx;
  logic                 start, start_rd, busy, op_rd_q, done;
  logic                 rise_stb, fall_stb;

  assign new_addr.phy   = reg_wdata[PHY_LSB +: PHY_AW];
  assign new_addr.regad = reg_wdata[REG_LSB +: REG_AW];
  assign frame          = build_frame(start_rd, new_addr, data_q);

  mdio_reg_file u_regs (
    .clk, .rst_n,
    .wr_en    (reg_wr_en),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .busy     (busy),
    .op_rd    (op_rd_q),
    .done     (done),
    .rx_data  (rx_data),
    .addr     (addr),
    .data     (data_q),
    .start    (start),
    .start_rd (start_rd),
    .rdata    (reg_rdata)
  );

  mdio_clk_div #(.HALF_DIV(MDC_HALF_DIV)) u_div (
    .clk, .rst_n,
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk, .rst_n,
    .start    (start),
    .start_rd (start_rd),
    .frame    (frame),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .is_rd    (op_rd_q),
    .bit_idx  (bit_idx),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rx_data  (rx_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       op_rd,
  input logic                       mdc,
  input logic                       mdio_oe,
  input logic [IDX_W-1:0]           bit_idx,
  input logic [PHY_AW+REG_AW-1:0]   addr_bits
);
  localparam int FRAME_CYC = 2 * FRAME_LEN * HALF_DIV;

  logic [15:0] hold_cnt;
  logic [15:0] busy_cnt;
  logic        mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      busy_cnt <= '0;
      mdc_q    <= 1'b0;
    end else begin
      mdc_q <= mdc;
      if (!busy)              hold_cnt <= '0;
      else if (mdc != mdc_q)  hold_cnt <= '0;
      else                    hold_cnt <= hold_cnt + 1'b1;
      if (!busy) busy_cnt <= '0;
      else       busy_cnt <= busy_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R8
  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hold_cnt <= 16'(HALF_DIV))); // R8
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 16'(FRAME_CYC))); // R8
  AST_DRIVE_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (bit_idx < IDX_W'(TA_SLOT))) |-> mdio_oe); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_rd && (bit_idx >= IDX_W'(TA_SLOT))) |-> !mdio_oe); // R6
  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_bits)); // R9
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.HALF_DIV(MDC_HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .op_rd     (op_rd_q),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe),
  .bit_idx   (bit_idx),
  .addr_bits (addr)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails = 0;

  // PHY model state
  logic        phy_present = 1'b0;
  logic [15:0] pat = '0;
  int          rise_cnt = 0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;

  // per-frame observations
  int          hi_cnt;
  logic [15:0] mid_ctrl, end_ctrl, snap_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_HALF_DIV(HALF)) u_mdio_mgmt_ctrl (
    .clk, .rst_n, .reg_wr_en, .reg_sel, .reg_wdata, .reg_rdata,
    .mdc, .mdio_i, .mdio_o, .mdio_oe
  );

  assign mdio_i = mdio_oe ? mdio_o :
                  ((phy_present && rise_cnt >= 48 && rise_cnt <= 63) ? pat[63 - rise_cnt] : 1'b1);

  always @(posedge mdc) begin
    cap_o    <= {cap_o[62:0], mdio_o};
    cap_oe   <= {cap_oe[62:0], mdio_oe};
    rise_cnt <= rise_cnt + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_wr_en = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic read_data(output logic [15:0] v);
    reg_sel = 1'b1; #1; v = reg_rdata; reg_sel = 1'b0; #1;
  endtask

  // start a frame and follow it to the edge on which it must finish
  task automatic do_frame(input logic [15:0] ctrl, input bit intrude);
    rise_cnt = 0; hi_cnt = 0;
    write_reg(1'b0, ctrl);
    for (int i = 1; i < FRAME_CYC; i++) begin
      @(posedge clk); #1;
      if (mdc) hi_cnt++;
      if (intrude) begin
        if (i == 100) begin reg_sel = 1'b0; reg_wdata = 16'h3E12; reg_wr_en = 1'b1; end
        if (i == 101) begin reg_sel = 1'b1; reg_wdata = 16'hBEEF; end
        if (i == 102) begin reg_wr_en = 1'b0; reg_sel = 1'b0; end
        if (i == 103) snap_ctrl = reg_rdata;
      end
    end
    mid_ctrl = reg_rdata;
    @(posedge clk); #1;
    end_ctrl = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 control after reset", 64'(reg_rdata), 64'h0);
    read_data(d);
    chk("R1 data after reset", 64'(d), 64'h0);
    chk("R1 mdc low after reset", 64'(mdc), 64'h0);
    chk("R1 mdio released after reset", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_noop_fields();
    write_reg(1'b0, 16'h2A50);
    chk("R2 fields read back", 64'(reg_rdata), 64'h2A50);
    repeat (20) @(posedge clk);
    #1;
    chk("R2 no frame: mdc idle", 64'(mdc), 64'h0);
    chk("R2 no frame: no rising mdc", 64'(rise_cnt), 64'h0);
    chk("R2 no frame: op bits clear", 64'(reg_rdata[1:0]), 64'h0);
  endtask

  task automatic t_read();
    logic [15:0] d;
    phy_present = 1'b1; pat = 16'hA5C3;
    do_frame(16'h0A21, 1'b0);
    chk("R3 read bit set at last busy cycle", 64'(mid_ctrl), 64'h0A21);
    chk("R3 read bit clears at frame end", 64'(end_ctrl), 64'h0A20);
    chk("R5 read header bits", 64'(cap_o[63:18]),
        64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'd5, 5'd2}));
    chk("R6 read release pattern", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
    read_data(d);
    chk("R6 read result", 64'(d), 64'hA5C3);
    chk("R8 mdc high cycles per frame", 64'(hi_cnt), 64'(64 * HALF));
    chk("R8 rising edges per frame", 64'(rise_cnt), 64'd64);
  endtask

  task automatic t_write();
    logic [15:0] d;
    phy_present = 1'b1;
    write_reg(1'b1, 16'h1234);
    do_frame(16'h3F12, 1'b0);
    chk("R4 write bit set at last busy cycle", 64'(mid_ctrl), 64'h3F12);
    chk("R4 write bit clears at frame end", 64'(end_ctrl), 64'h3F10);
    chk("R5 full write frame", cap_o,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd31, 5'd17, 2'b10, 16'h1234});
    chk("R4 write drives every bit", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    read_data(d);
    chk("R4 data register unchanged", 64'(d), 64'h1234);
  endtask

  task automatic t_absent();
    logic [15:0] d;
    phy_present = 1'b0;
    do_frame(16'h0001, 1'b0);
    read_data(d);
    chk("R7 absent phy returns all ones", 64'(d), 64'hFFFF);
    chk("R7 op bit cleared", 64'(end_ctrl), 64'h0000);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d;
    phy_present = 1'b1; pat = 16'h0F5A;
    do_frame(16'h0611, 1'b1);
    chk("R9 control write ignored while busy", 64'(snap_ctrl), 64'h0611);
    chk("R9 frame header unchanged", 64'(cap_o[63:18]),
        64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd1}));
    chk("R9 fields after frame", 64'(end_ctrl), 64'h0610);
    read_data(d);
    chk("R9 data write ignored, read result kept", 64'(d), 64'h0F5A);
  endtask

  task automatic t_both_bits();
    logic [15:0] d;
    phy_present = 1'b1; pat = 16'hC001;
    do_frame(16'h0E93, 1'b0);
    chk("R3 both bits give read", 64'(mid_ctrl), 64'h0E91);
    chk("R3 read opcode on wire", 64'(cap_o[29:28]), 64'h2);
    read_data(d);
    chk("R3 both bits read result", 64'(d), 64'hC001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_noop_fields();
    t_read();
    t_write();
    t_absent();
    t_busy_ignore();
    t_both_bits();
    summary();
    $finish;
  end
endmodule